// File: doc/BRIEF.md
# Sleep-State Programmable LED Blinker

This block drives two open-drain indicator LEDs, a power LED and a suspend LED, from the current system sleep state. The sleep state arrives as a 2-bit code. Each LED has its own 10-bit setting word, which holds five 2-bit state-code fields. The block compares every field with the current state code. The highest-placed matching field selects one of five behaviours: release the pin, blink at 1 Hz, blink at 0.5 Hz, blink at 0.25 Hz, or pull the pin low all the time.

The blink rates are derived from a 1 kHz timebase tick. One shared divider chain produces all three rates, so their edges stay aligned. The chain starts again only on reset. A single invert control flips the blink clock for both LEDs. Register storage lives outside the block, and the setting words come in as plain inputs. Each LED output has two signals. The first is a drive-low enable for the pad. The second is a release flag, set while the selected behaviour is a static release.

Top module: `led_state_blinker`

## Requirements
- R1: The state code `state_code_i` is read as 11 = S0, 01 = S3, 00 = S5, with 10 reserved. Field k of a setting word is bits [2k+1:2k], with k from 0 to 4. A field matches when its 2-bit value equals `state_code_i`, and the reserved code 10 is compared in the same way as the other codes.
- R2: When field 4 (bits [9:8]) matches, `*_release_o` is 1 and `*_drive_low_o` is 0.
- R3: When field 3 (bits [7:6]) is the selected field, the LED blinks at 1 Hz with 50% duty. The blink level is bit 0 of a phase counter that advances once every HALF_TICKS ticks (default 500).
- R4: When field 2 (bits [5:4]) is the selected field, the LED blinks at 0.5 Hz and follows phase bit 1. When field 1 (bits [3:2]) is the selected field, the LED blinks at 0.25 Hz and follows phase bit 2. While an LED blinks, `*_release_o` is 0.
- R5: When field 0 (bits [1:0]) is the selected field, `*_drive_low_o` is 1 continuously and `*_release_o` is 0.
- R6: When several fields match, the field with the highest index is the one selected.
- R7: When no field matches, the output is released: `*_release_o` is 1 and `*_drive_low_o` is 0.
- R8: With `invert_i` low, a blinking LED pulls its pin low while its phase bit is 1. With `invert_i` high, it pulls its pin low while its phase bit is 0. This applies to both LEDs.
- R9: Both LEDs share one phase counter, which reset clears to 0. Bit i+1 of the counter changes only when bit i falls. Changes to the state or to the setting words never restart the counter.
- R10: The phase counter advances only on cycles where `tick_1k_i` is high. Outputs are registered and show the inputs one clock later. During reset, both LEDs are released and not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_code_i | input | 2 | Sleep state code {S3_N, S5_N} |
| pwr_cfg_i | input | 10 | Power LED setting word |
| sus_cfg_i | input | 10 | Suspend LED setting word |
| invert_i | input | 1 | Inverts the blink clock for both LEDs |
| tick_1k_i | input | 1 | One-cycle pulse at 1 kHz |
| pwr_drive_low_o | output | 1 | Power LED pad pull-low enable |
| pwr_release_o | output | 1 | Power LED in static release |
| sus_drive_low_o | output | 1 | Suspend LED pad pull-low enable |
| sus_release_o | output | 1 | Suspend LED in static release |

## Verification
A divider wrap and a change of state or setting can fall in the same clock. In that cycle, the output must show the new field selection, applied to the phase value from before the wrap. The bench provokes this by changing the state code, the setting words and the invert control at random on every cycle, with ticks on most cycles, so changes land on wrap cycles many times. A directed step also changes the state in the middle of a blink period. Each output is compared with a bench model built from the tick count and the field priority. That model shows whether the phase was lost or restarted, and whether the old or new field was applied.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;
  localparam int unsigned FIELD_W    = 2;
  localparam int unsigned NUM_FIELDS = 5;
  localparam int unsigned CFG_W      = FIELD_W * NUM_FIELDS;
  localparam int unsigned NUM_RATES  = 3;

  typedef enum logic [2:0] {
    MODE_RELEASE,
    MODE_BLINK_1HZ,
    MODE_BLINK_HALF,
    MODE_BLINK_QUARTER,
    MODE_LOW
  } led_mode_e;
endpackage

// File: rtl/blink_divider.sv
module blink_divider #(
  parameter int unsigned HALF_TICKS = 500,
  parameter int unsigned RATES      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [RATES-1:0] phase_o
);
  localparam int unsigned CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [RATES-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q   <= '0;
        phase_q <= phase_q + RATES'(1);
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign phase_o = phase_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

  // R10
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_q) && $stable(cnt_q));

  // R9: slower rates step only on a falling edge of the next faster one
  for (genvar i = 1; i < RATES; i++) begin : g_cascade
    rate_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(phase_q[i]) |-> $fell(phase_q[i-1]));
  end
endmodule

// File: rtl/led_mode_select.sv
module led_mode_select
  import led_blink_pkg::*;
(
  input  logic [FIELD_W-1:0] state_i,
  input  logic [CFG_W-1:0]   cfg_i,
  output led_mode_e          mode_o
);
  logic [NUM_FIELDS-1:0] match;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_match
    assign match[f] = (cfg_i[f*FIELD_W +: FIELD_W] == state_i);
  end

  function automatic led_mode_e field_mode(input int f);
    case (f)
      0:       return MODE_LOW;
      1:       return MODE_BLINK_QUARTER;
      2:       return MODE_BLINK_HALF;
      3:       return MODE_BLINK_1HZ;
      default: return MODE_RELEASE;
    endcase
  endfunction

  // later (higher) fields override lower ones
  always_comb begin
    mode_o = MODE_RELEASE;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (match[f]) mode_o = field_mode(f);
    end
  end
endmodule

// File: rtl/led_pin_driver.sv
module led_pin_driver
  import led_blink_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  led_mode_e            mode_i,
  input  logic [NUM_RATES-1:0] phase_i,
  input  logic                 invert_i,
  output logic                 drive_low_o,
  output logic                 release_o
);
  logic drive_d, release_d, drive_q, release_q;

  always_comb begin
    drive_d   = 1'b0;
    release_d = 1'b0;
    case (mode_i)
      MODE_LOW:           drive_d = 1'b1;
      MODE_BLINK_1HZ:     drive_d = phase_i[0] ^ invert_i;
      MODE_BLINK_HALF:    drive_d = phase_i[1] ^ invert_i;
      MODE_BLINK_QUARTER: drive_d = phase_i[2] ^ invert_i;
      default:            release_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q   <= 1'b0;
      release_q <= 1'b1;
    end else begin
      drive_q   <= drive_d;
      release_q <= release_d;
    end
  end

  assign drive_low_o = drive_q;
  assign release_o   = release_q;

  // R2
  release_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_q |-> !drive_q);

  // R5
  steady_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == MODE_LOW |=> drive_q && !release_q);

  // R4
  blink_not_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BLINK_HALF || mode_i == MODE_BLINK_QUARTER) |=> !release_q);
endmodule

// File: rtl/led_state_blinker.sv
module led_state_blinker
  import led_blink_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 500
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] state_code_i,
  input  logic [9:0] pwr_cfg_i,
  input  logic [9:0] sus_cfg_i,
  input  logic       invert_i,
  input  logic       tick_1k_i,
  output logic       pwr_drive_low_o,
  output logic       pwr_release_o,
  output logic       sus_drive_low_o,
  output logic       sus_release_o
);
  localparam int unsigned NUM_LEDS = 2;

  logic [NUM_RATES-1:0]            phase;
  logic [NUM_LEDS-1:0][CFG_W-1:0]  cfg_w;
  logic [NUM_LEDS-1:0]             drive_w;
  logic [NUM_LEDS-1:0]             release_w;

  assign cfg_w[0] = pwr_cfg_i;
  assign cfg_w[1] = sus_cfg_i;

  blink_divider #(
    .HALF_TICKS (HALF_TICKS),
    .RATES      (NUM_RATES)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_1k_i),
    .phase_o (phase)
  );

  for (genvar l = 0; l < NUM_LEDS; l++) begin : g_led
    led_mode_e mode;

    led_mode_select u_sel (
      .state_i (state_code_i),
      .cfg_i   (cfg_w[l]),
      .mode_o  (mode)
    );

    led_pin_driver u_drv (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .mode_i      (mode),
      .phase_i     (phase),
      .invert_i    (invert_i),
      .drive_low_o (drive_w[l]),
      .release_o   (release_w[l])
    );
  end

  assign pwr_drive_low_o = drive_w[0];
  assign pwr_release_o   = release_w[0];
  assign sus_drive_low_o = drive_w[1];
  assign sus_release_o   = release_w[1];

  // R6: a top-field match in the previous cycle must leave the pin released
  top_field_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_cfg_i[9:8] == state_code_i) |=> pwr_release_o && !pwr_drive_low_o);
endmodule

// File: tb/led_state_blinker_tb.sv
`timescale 1ns/1ps
module led_state_blinker_tb;
  localparam int unsigned HALF = 500;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] state = 2'b11;
  logic [9:0] pcfg = '0;
  logic [9:0] scfg = '0;
  logic       inv = 1'b0;
  logic       tick = 1'b0;
  logic       p_drv, p_rel, s_drv, s_rel;

  int unsigned checks = 0;
  int unsigned fails  = 0;
  int unsigned ticks  = 0;
  bit          done   = 0;

  always #2 clk = ~clk;

  led_state_blinker #(.HALF_TICKS(HALF)) u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .state_code_i    (state),
    .pwr_cfg_i       (pcfg),
    .sus_cfg_i       (scfg),
    .invert_i        (inv),
    .tick_1k_i       (tick),
    .pwr_drive_low_o (p_drv),
    .pwr_release_o   (p_rel),
    .sus_drive_low_o (s_drv),
    .sus_release_o   (s_rel)
  );

  // highest matching field index, -1 if none
  function automatic int pick_field(logic [1:0] st, logic [9:0] cfg);
    int r = -1;
    for (int f = 0; f < 5; f++) if (cfg[2*f +: 2] == st) r = f;
    return r;
  endfunction

  function automatic string req_of(int f);
    case (f)
      -1:      return "R7";
      4:       return "R2";
      3:       return "R3";
      0:       return "R5";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [1:0] exp_out(int f, logic i, int unsigned t);
    logic [1:0] r;
    int unsigned ph = (t / HALF) % 8;
    if (f == -1 || f == 4) r = 2'b10;
    else if (f == 0) r = 2'b01;
    else r = {1'b0, (1'((ph >> (3 - f)) & 1)) ^ i};
    return r;
  endfunction

  task automatic check_led(string name, string tag, int f, logic rel, logic drv,
                           logic [1:0] e);
    checks++;
    if ({rel, drv} !== e) begin
      fails++;
      $display("FAIL %s %s/%s: rel=%0b drv=%0b expected rel=%0b drv=%0b",
               name, tag, req_of(f), rel, drv, e[1], e[0]);
    end
  endtask

  // called at a falling edge; drives, clocks, samples at next falling edge
  task automatic step(logic [1:0] st, logic [9:0] pc, logic [9:0] sc,
                      logic i, logic tk, string tag);
    int fp, fs;
    logic [1:0] ep, es;
    state = st; pcfg = pc; scfg = sc; inv = i; tick = tk;
    fp = pick_field(st, pc);
    fs = pick_field(st, sc);
    ep = exp_out(fp, i, ticks);
    es = exp_out(fs, i, ticks);
    @(posedge clk);
    if (tk) ticks++;
    @(negedge clk);
    check_led("pwr", tag, fp, p_rel, p_drv, ep);
    check_led("sus", tag, fs, s_rel, s_drv, es);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1ed5));
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (!(p_rel && !p_drv && s_rel && !s_drv)) begin
      fails++;
      $display("FAIL R10 reset: pwr rel=%0b drv=%0b sus rel=%0b drv=%0b expected 1/0 1/0",
               p_rel, p_drv, s_rel, s_drv);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // default-like words in S0: pwr low (R5), sus no match (R7)
    step(2'b11, 10'h09B, 10'h098, 1'b0, 1'b0, "R1");
    // S3: both 0.5 Hz, phase 0
    step(2'b01, 10'h09B, 10'h098, 1'b0, 1'b0, "R1");
    // S5: top field and low field both match on sus (R6)
    step(2'b00, 10'h09B, 10'h098, 1'b0, 1'b0, "R6");
    // all fields match -> release; top field 11 in S0 -> 1 Hz beats low
    step(2'b00, 10'h000, 10'h000, 1'b0, 1'b0, "R6");
    step(2'b11, 10'h0FF, 10'h03F, 1'b0, 1'b0, "R6");
    // reserved code 10 selects 0.25 Hz via field 1
    step(2'b10, 10'b01_01_01_10_01, 10'b10_10_10_10_10, 1'b0, 1'b0, "R1");
    // invert at phase 0: 1 Hz pulls low
    step(2'b11, 10'b00_11_00_00_00, 10'b00_00_11_00_00, 1'b1, 1'b0, "R8");
    // ticks held low: phase must not advance
    for (int k = 0; k < 700; k++)
      step(2'b11, 10'b00_11_00_00_00, 10'b00_00_00_11_00, 1'b0, 1'b0, "R10");
    // run into first 1 Hz half-period, then change state mid-period
    for (int k = 0; k < 620; k++)
      step(2'b11, 10'b00_11_00_00_00, 10'b00_00_11_00_00, 1'b0, 1'b1, "R3");
    for (int k = 0; k < 40; k++)
      step(2'b01, 10'b00_01_00_00_00, 10'b00_00_00_01_00, k[0], 1'b1, "R9");
    for (int k = 0; k < 2000; k++)
      step(2'b00, 10'b11_11_00_11_11, 10'b11_11_11_00_11, 1'b0, 1'b1, "R4");

    // random mix, state/cfg/invert may change on wrap cycles
    for (int k = 0; k < 24000; k++) begin
      logic [1:0] st = 2'($urandom);
      logic [9:0] pc = 10'($urandom);
      logic [9:0] sc = 10'($urandom);
      logic       i  = 1'($urandom);
      logic       tk = (($urandom % 8) != 0);
      step(st, pc, sc, i, tk, "R9");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule